// File: doc/BRIEF.md
# Configurable GPIO Port Bank Controller

This block holds the control state for a bank of general-purpose pins and turns it into per-pin pad-driver enables. Every pin carries a mode bit (digital or analog) and an output-type bit (push-pull or open-drain). An output latch supplies the value each pin drives. One pull-up kill bit switches off the weak pull-ups on the whole bank. The enables it produces are high-side drive, low-side drive, weak pull-up and digital receiver.

Software reaches the bank through a plain single-cycle write port and a combinational read port. The pad level comes back through a two-flop synchronizer. A read of the input address returns the synchronized levels, and every pin in analog mode reads as 0 there. The pad cells, analog routing and peripheral multiplexing live outside this block.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is held and after it is released, every pin is digital, drives nothing, has its weak pull-up on and its receiver on. Reads return 0xFF at address 0, 0x00 at address 1 and 0x00 at address 3.
- R2: A mode bit of 1 makes its pin digital and a mode bit of 0 makes it analog. An analog pin has its receiver off, its pull-up off and both drivers off, whatever its latch and output-type bits hold.
- R3: At address 2, each analog pin reads back as 0 whatever level is on its pad.
- R4: A digital push-pull pin (output-type bit 1) asserts the high-side enable when its latch bit is 1 and the low-side enable when it is 0.
- R5: A digital open-drain pin (output-type bit 0) never asserts the high-side enable. It asserts the low-side enable only when its latch bit is 0.
- R6: The weak pull-up of a digital pin is on when that pin is not driving low and the pull-up kill bit is 0. It is off whenever the low-side enable is on, and it is off on every pin while the kill bit is 1.
- R7: At address 2, a digital pin returns the pad level sampled two clock edges earlier, and never its own latch value.
- R8: A write lands at the clock edge where reg_we_i is high. Address 0 is the mode register, address 1 the output-type register, address 2 the output latch and address 3 bit 0 the pull-up kill bit. Reads at addresses 0, 1 and 3 return the stored configuration, with the upper bits of address 3 reading 0.
- R9: No pin ever asserts its high-side and low-side enables together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | N_PINS | Write data |
| reg_rdata_o | output | N_PINS | Combinational read data |
| pad_i | input | N_PINS | Raw pad levels |
| drv_hi_o | output | N_PINS | High-side driver enable per pin |
| drv_lo_o | output | N_PINS | Low-side driver enable per pin |
| pull_en_o | output | N_PINS | Weak pull-up enable per pin |
| rx_en_o | output | N_PINS | Digital receiver enable per pin |

## Verification
The bench drives random combinations of mode, output-type, latch and kill bits, so all four mode/type pairings sit side by side within one byte. A swapped or missing gate then shows up on the affected pins only. Pad levels are drawn independently of the latch, which separates a readback of the pad from a readback of the latch. Directed cases cover the reset state, an all-analog bank against an all-high pad, and the kill bit on a bank that drives nothing. Each such case isolates one enable term from the others.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE  = 2'd0,
    ADDR_OTYPE = 2'd1,
    ADDR_LATCH = 2'd2,
    ADDR_CTRL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] mode_o,
  output logic [N_PINS-1:0] otype_o,
  output logic [N_PINS-1:0] latch_o,
  output logic              pud_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '1;
      otype_o <= '0;
      latch_o <= '1;
      pud_o   <= 1'b0;
    end else if (we_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_MODE:  mode_o  <= wdata_i;
        ADDR_OTYPE: otype_o <= wdata_i;
        ADDR_LATCH: latch_o <= wdata_i;
        ADDR_CTRL:  pud_o   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assert_mode_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MODE) |=> (mode_o == $past(wdata_i)));
  assert_latch_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_LATCH) |=> (latch_o == $past(wdata_i)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mode_o) && $stable(otype_o) && $stable(latch_o) && $stable(pud_o)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] mode_i,
  input  logic [N_PINS-1:0] otype_i,
  input  logic [N_PINS-1:0] latch_i,
  input  logic              pud_i,
  output logic [N_PINS-1:0] drv_hi_o,
  output logic [N_PINS-1:0] drv_lo_o,
  output logic [N_PINS-1:0] pull_en_o,
  output logic [N_PINS-1:0] rx_en_o
);
  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    logic dig, lo;
    always_comb begin
      dig          = mode_i[k];
      lo           = dig & ~latch_i[k];
      drv_lo_o[k]  = lo;
      drv_hi_o[k]  = dig & otype_i[k] & latch_i[k];
      pull_en_o[k] = dig & ~lo & ~pud_i;
      rx_en_o[k]   = dig;
    end

    assert_analog_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_i[k] |-> !(drv_hi_o[k] || drv_lo_o[k] || pull_en_o[k] || rx_en_o[k]));
    assert_od_no_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !otype_i[k] |-> !drv_hi_o[k]);
    assert_pull_vs_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_lo_o[k] |-> !pull_en_o[k]);
    assert_no_shoot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drv_hi_o[k] && drv_lo_o[k]));
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pad_i,
  input  logic [N_PINS-1:0] mode_i,
  output logic [N_PINS-1:0] level_o
);
  logic [N_PINS-1:0] ff1_q, ff2_q;
  logic [1:0]        warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q  <= '0;
      ff2_q  <= '0;
      warm_q <= '0;
    end else begin
      ff1_q <= pad_i;
      ff2_q <= ff1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign level_o = ff2_q & mode_i;

  // latency check only once both stages hold post-reset samples
  assert_two_stage_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (level_o == ($past(pad_i, 2) & mode_i)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N_PINS-1:0] reg_wdata_i,
  output logic [N_PINS-1:0] reg_rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] drv_hi_o,
  output logic [N_PINS-1:0] drv_lo_o,
  output logic [N_PINS-1:0] pull_en_o,
  output logic [N_PINS-1:0] rx_en_o
);
  logic [N_PINS-1:0] mode, otype, latch, level;
  logic              pud;

  gpio_cfg_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .mode_o(mode), .otype_o(otype), .latch_o(latch),
    .pud_o(pud)
  );

  gpio_pad_ctrl #(.N_PINS(N_PINS)) u_pad (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .otype_i(otype),
    .latch_i(latch), .pud_i(pud), .drv_hi_o(drv_hi_o), .drv_lo_o(drv_lo_o),
    .pull_en_o(pull_en_o), .rx_en_o(rx_en_o)
  );

  gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(pad_i), .mode_i(mode),
    .level_o(level)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_MODE:  reg_rdata_o = mode;
      ADDR_OTYPE: reg_rdata_o = otype;
      ADDR_LATCH: reg_rdata_o = level;
      ADDR_CTRL:  reg_rdata_o[0] = pud;
      default: ;
    endcase
  end

  assert_analog_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_LATCH) |-> ((reg_rdata_o & ~rx_en_o) == '0));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pad = '0;
  logic [N-1:0] drv_hi, drv_lo, pull_en, rx_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [N-1:0] m_mode, m_otype, m_latch;
  logic         m_pud;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.N_PINS(N)) u_gpio_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pad_i(pad),
    .drv_hi_o(drv_hi), .drv_lo_o(drv_lo), .pull_en_o(pull_en), .rx_en_o(rx_en)
  );

  function automatic logic [N-1:0] exp_hi();
    return m_mode & m_otype & m_latch;
  endfunction
  function automatic logic [N-1:0] exp_lo();
    return m_mode & ~m_latch;
  endfunction
  function automatic logic [N-1:0] exp_pull();
    return m_pud ? '0 : (m_mode & m_latch);
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
    case (a)
      2'd0: m_mode = d;
      2'd1: m_otype = d;
      2'd2: m_latch = d;
      default: m_pud = d[0];
    endcase
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [N-1:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic check_drivers();
    @(negedge clk);
    check("R4/R5 drv_hi", drv_hi, exp_hi());
    check("R2/R4/R5 drv_lo", drv_lo, exp_lo());
    check("R6 pull_en", pull_en, exp_pull());
    check("R2 rx_en", rx_en, m_mode);
    check("R9 no overlap", drv_hi & drv_lo, '0);
  endtask

  // hold pad, let two edges pass, then read address 2
  task automatic pad_check(string req, logic [N-1:0] p);
    @(negedge clk);
    pad = p;
    repeat (3) @(posedge clk);
    rd_check(req, 2'd2, p & m_mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    m_mode = '1; m_otype = '0; m_latch = '1; m_pud = 1'b0;
    pad = 8'h5A;
    repeat (2) @(posedge clk);
    #1;
    // R1 during reset
    check("R1 reset drv_hi", drv_hi, '0);
    check("R1 reset drv_lo", drv_lo, '0);
    check("R1 reset pull", pull_en, '1);
    check("R1 reset rx", rx_en, '1);
    @(negedge clk) rst_n = 1'b1;
    rd_check("R1 mode read", 2'd0, 8'hFF);
    rd_check("R1 otype read", 2'd1, 8'h00);
    rd_check("R1 ctrl read", 2'd3, 8'h00);
    check_drivers();

    // R3 all analog against high pad
    wr(2'd0, 8'h00);
    check_drivers();
    pad_check("R3 analog reads 0", 8'hFF);

    // R7 digital reads pad not latch
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h0F);
    pad_check("R7 pad not latch", 8'hF0);

    // R6 kill bit on a non-driving bank
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd_check("R8 ctrl upper bits zero", 2'd3, 8'h01);
    check_drivers();
    wr(2'd3, 8'h00);
    check_drivers();

    // R4 push-pull alternating latch
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hA5);
    check_drivers();

    // R8 readback of configuration
    rd_check("R8 otype read", 2'd1, 8'hFF);

    // R7 two-edge latency: level not yet visible after one edge
    @(negedge clk) pad = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) pad = 8'hC3; addr = 2'd2;
    @(posedge clk);
    #1 check("R7 one edge still old", rdata, 8'h00);
    @(posedge clk);
    #1 check("R7 two edges new", rdata, 8'hC3);

    // random mix
    for (int i = 0; i < 200; i++) begin
      wr(2'($urandom_range(0, 3)), N'($urandom));
      check_drivers();
      if (i % 4 == 0) begin
        rd_check("R8 mode read", 2'd0, m_mode);
        rd_check("R8 otype read", 2'd1, m_otype);
        rd_check("R8 ctrl read", 2'd3, {7'd0, m_pud});
        pad_check("R3/R7 random pad", N'($urandom));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule